// File: doc/BRIEF.md
# DRAM Idle Page-Close Timer

This block tracks the open row of every bank in a DRAM controller and labels each incoming request as a page hit, a page miss or a page conflict. Each bank has an idle counter. The counter advances on every cycle in which the bank holds an open row, has no precharge outstanding and receives no request. When the counter passes a programmable limit, the block raises a precharge request for that bank. A refresh request forces a precharge on every open bank, whatever the counters hold.

A 3-bit setting selects the idle limit. It offers five fixed cycle counts, a "never close on idle" choice and an "auto" choice that falls back to 16 cycles. A precharge request stays up until the controller acknowledges it on that bank's acknowledge line. On that acknowledge the bank either closes, or it opens the row of the last request that arrived while the precharge was outstanding.

Top module: `dram_page_closer`

## Requirements
- R1: After a synchronous reset every bank is closed (`row_open` all 0), no precharge request is raised and `cls_valid` is 0.
- R2: A request to a closed bank is reported one cycle later with `cls_valid`=1 and `cls_kind`=2'b10 (miss), and the bank shows open from that cycle on.
- R3: A request to the bank's open row is reported as 2'b01 (hit). A request to a different row of an open bank is reported as 2'b11 (conflict) and raises that bank's `pre_req` bit in the following cycle while the old row stays open.
- R4: Any request to a bank clears that bank's idle counter. Requests to other banks do not clear it.
- R5: With limit L, `pre_req` rises at the clock edge that ends the (L+1)-th consecutive idle cycle of an open bank. `limit_sel` codes: 3'b000=0, 3'b001=16, 3'b010=32, 3'b011=64, 3'b100=96, 3'b110 and 3'b111 = auto = 16.
- R6: With `limit_sel`=3'b101 (never), an open bank raises no precharge request however long it stays idle.
- R7: A raised `pre_req` bit holds until the same bit of `pre_ack` is seen, and drops in the next cycle. If no request reached the bank meanwhile, the bank is then closed. An acknowledge on a bank with no request outstanding has no effect.
- R8: A `refresh_req` pulse raises `pre_req` in the next cycle on every open bank, including under the never setting, and leaves closed banks alone. After acknowledge those banks are closed.
- R9: A request to a bank whose precharge is outstanding is classified against the row that is still open. After the acknowledge the bank reopens at that request's row, unless a refresh intervened.
- R10: If the limit is lowered below a bank's current idle count, the bank raises `pre_req` at the end of its next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_bank | input | 3 | Target bank of the request |
| req_row | input | 16 | Target row of the request |
| limit_sel | input | 3 | Idle limit code |
| refresh_req | input | 1 | Force precharge of all open banks |
| pre_ack | input | 8 | Per-bank precharge-done acknowledge |
| cls_valid | output | 1 | Classification valid (one cycle after request) |
| cls_kind | output | 2 | 01 hit, 10 miss, 11 conflict |
| pre_req | output | 8 | Per-bank precharge request |
| row_open | output | 8 | Per-bank open-row flag |

## Verification
A wrong open-row flag or stored row shows up at the very next request to that bank, as a miss where a hit or conflict was due or the other way round. A corrupted idle counter or limit decode moves the rising edge of a bank's precharge request by at least one cycle, so the bench samples that bit one cycle before and at the exact expected edge. A lost pending-row record shows up one cycle after the acknowledge, when the bank reads closed or a follow-up request is classified wrongly.

// File: rtl/pg_pkg.sv
package pg_pkg;

    localparam int MAX_LIMIT = 96;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    typedef enum logic [1:0] {
        PG_NONE     = 2'b00,
        PG_HIT      = 2'b01,
        PG_MISS     = 2'b10,
        PG_CONFLICT = 2'b11
    } pg_class_e;

    typedef enum logic [2:0] {
        LIM_0     = 3'b000,
        LIM_16    = 3'b001,
        LIM_32    = 3'b010,
        LIM_64    = 3'b011,
        LIM_96    = 3'b100,
        LIM_NEVER = 3'b101,
        LIM_AUTO0 = 3'b110,
        LIM_AUTO1 = 3'b111
    } lim_code_e;

    localparam int AUTO_LIMIT = 16;

    typedef struct packed {
        logic             valid;
        logic             pre;
        logic             pend;
        logic [CNT_W-1:0] cnt;
    } bank_ctl_t;

    typedef struct packed {
        logic [CNT_W-1:0] cycles;
        logic             never;
    } limit_t;

    function automatic limit_t decode_limit(input lim_code_e code);
        limit_t r;
        r.never = 1'b0;
        case (code)
            LIM_0:     r.cycles = CNT_W'(0);
            LIM_16:    r.cycles = CNT_W'(16);
            LIM_32:    r.cycles = CNT_W'(32);
            LIM_64:    r.cycles = CNT_W'(64);
            LIM_96:    r.cycles = CNT_W'(96);
            LIM_NEVER: begin
                r.cycles = CNT_W'(MAX_LIMIT);
                r.never  = 1'b1;
            end
            default:   r.cycles = CNT_W'(AUTO_LIMIT);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/page_limit_decode.sv
module page_limit_decode
    import pg_pkg::*;
(
    input  logic [2:0]       code,
    output logic [CNT_W-1:0] limit,
    output logic             never
);
    limit_t dec;

    always_comb begin
        dec   = decode_limit(lim_code_e'(code));
        limit = dec.cycles;
        never = dec.never;
    end

    // R5
    always_comb begin
        auto_default_chk: assert (!(code[2:1] == 2'b11) || (limit == CNT_W'(AUTO_LIMIT) && !never));
    end

endmodule

// File: rtl/page_bank_slot.sv
module page_bank_slot
    import pg_pkg::*;
#(
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic [ROW_W-1:0] req_row,
    input  logic [CNT_W-1:0] limit,
    input  logic             never,
    input  logic             refresh,
    input  logic             ack,
    output logic             is_open,
    output logic             pre_req,
    output pg_class_e        kind
);
    bank_ctl_t        cur, nx;
    logic [ROW_W-1:0] open_row, nrow;
    logic [ROW_W-1:0] pend_row, nprow;
    logic             idle;

    assign idle = cur.valid && !cur.pre && !sel;

    always_comb begin
        if (!cur.valid)
            kind = PG_MISS;
        else if (open_row == req_row)
            kind = PG_HIT;
        else
            kind = PG_CONFLICT;
    end

    always_comb begin
        nx    = cur;
        nrow  = open_row;
        nprow = pend_row;

        if (sel) begin
            nx.cnt = '0;
            if (!cur.valid) begin
                nx.valid = 1'b1;
                nrow     = req_row;
            end else if (cur.pre || kind == PG_CONFLICT) begin
                nx.pre  = 1'b1;
                nx.pend = 1'b1;
                nprow   = req_row;
            end
        end else if (idle && !never) begin
            if (cur.cnt >= limit)
                nx.pre = 1'b1;
            else
                nx.cnt = cur.cnt + CNT_W'(1);
        end

        if (refresh && nx.valid) begin
            nx.pre  = 1'b1;
            nx.pend = 1'b0;
        end

        if (cur.pre && ack) begin
            nx.pre   = 1'b0;
            nx.cnt   = '0;
            nx.valid = nx.pend;
            if (nx.pend)
                nrow = nprow;
            nx.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= '0;
            open_row <= '0;
            pend_row <= '0;
        end else begin
            cur      <= nx;
            open_row <= nrow;
            pend_row <= nprow;
        end
    end

    assign is_open = cur.valid;
    assign pre_req = cur.pre;

    // R7
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_req && !ack) |=> pre_req);

    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_req && ack) |=> !pre_req);

    // R8
    refresh_force_chk: assert property (@(posedge clk) disable iff (rst)
        (refresh && is_open && !(pre_req && ack)) |=> pre_req);

    // R6
    never_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (never && !refresh && idle) |=> !pre_req);

    // R7
    pre_open_chk: assert property (@(posedge clk) disable iff (rst)
        pre_req |-> is_open);

endmodule

// File: rtl/page_class_reg.sv
module page_class_reg
    import pg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [BANK_W-1:0]           req_bank,
    input  logic [NUM_BANKS-1:0][1:0]   kinds,
    output logic                        cls_valid,
    output logic [1:0]                  cls_kind
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cls_valid <= 1'b0;
            cls_kind  <= PG_NONE;
        end else begin
            cls_valid <= req_valid;
            cls_kind  <= req_valid ? kinds[req_bank] : PG_NONE;
        end
    end
endmodule

// File: rtl/dram_page_closer.sv
module dram_page_closer
    import pg_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]     req_row,
    input  logic [2:0]           limit_sel,
    input  logic                 refresh_req,
    input  logic [NUM_BANKS-1:0] pre_ack,
    output logic                 cls_valid,
    output logic [1:0]           cls_kind,
    output logic [NUM_BANKS-1:0] pre_req,
    output logic [NUM_BANKS-1:0] row_open
);
    logic [CNT_W-1:0]           limit;
    logic                       never;
    logic [NUM_BANKS-1:0][1:0]  kinds;

    page_limit_decode u_dec (
        .code  (limit_sel),
        .limit (limit),
        .never (never)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pg_class_e k;
        page_bank_slot #(.ROW_W(ROW_W)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .sel     (req_valid && (req_bank == BANK_W'(b))),
            .req_row (req_row),
            .limit   (limit),
            .never   (never),
            .refresh (refresh_req),
            .ack     (pre_ack[b]),
            .is_open (row_open[b]),
            .pre_req (pre_req[b]),
            .kind    (k)
        );
        assign kinds[b] = k;
    end

    page_class_reg #(.NUM_BANKS(NUM_BANKS)) u_cls (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_bank  (req_bank),
        .kinds     (kinds),
        .cls_valid (cls_valid),
        .cls_kind  (cls_kind)
    );

    // R2
    miss_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !row_open[req_bank]) |=> (cls_valid && cls_kind == PG_MISS));

    // R2
    miss_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !row_open[req_bank] && !refresh_req) |=> row_open[$past(req_bank)]);

    // R1
    idle_no_class_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !cls_valid);

endmodule

// File: tb/tb_dram_page_closer.sv
`timescale 1ns/1ps
module tb_dram_page_closer;
    localparam logic [1:0] K_HIT = 2'b01, K_MISS = 2'b10, K_CONF = 2'b11;

    logic       clk = 0, rst = 1;
    logic       req_valid = 0;
    logic [2:0] req_bank = 0;
    logic [15:0] req_row = 0;
    logic [2:0] limit_sel = 3'b101;
    logic       refresh_req = 0;
    logic [7:0] pre_ack = 0;
    logic       cls_valid;
    logic [1:0] cls_kind;
    logic [7:0] pre_req, row_open;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    dram_page_closer dut (.*);

    always #10 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && cls_valid) begin
            if (exp_q.size() == 0) check("R2 unexpected class", {30'd0, cls_kind}, 32'd0);
            else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {30'd0, cls_kind}, {30'd0, e});
            end
        end
    end

    task automatic do_req(input logic [2:0] b, input logic [15:0] r, input logic [1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        req_valid = 1; req_bank = b; req_row = r;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic do_ack(input logic [7:0] m);
        pre_ack = m;
        @(negedge clk);
        pre_ack = 0;
    endtask

    task automatic do_refresh();
        refresh_req = 1;
        @(negedge clk);
        refresh_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        int lims[7];
        logic [2:0] codes[7];
        codes = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b110, 3'b111};
        lims  = '{0, 16, 32, 64, 96, 16, 16};

        idle(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 row_open", {24'd0, row_open}, 32'd0);
        check("R1 pre_req", {24'd0, pre_req}, 32'd0);
        check("R1 cls_valid", {31'd0, cls_valid}, 32'd0);

        // R2 / R3 with never-close limit
        limit_sel = 3'b101;
        do_req(0, 16'h1234, K_MISS, "R2 miss");
        check("R2 opens", {31'd0, row_open[0]}, 32'd1);
        do_req(0, 16'h1234, K_HIT, "R3 hit");
        do_req(0, 16'h5678, K_CONF, "R3 conflict");
        check("R3 conflict pre", {31'd0, pre_req[0]}, 32'd1);
        check("R3 still open", {31'd0, row_open[0]}, 32'd1);
        idle(5);
        check("R7 hold", {31'd0, pre_req[0]}, 32'd1);
        do_ack(8'h01);
        check("R7 drop", {31'd0, pre_req[0]}, 32'd0);
        check("R3 reopened", {31'd0, row_open[0]}, 32'd1);
        do_req(0, 16'h5678, K_HIT, "R3 new row hit");

        // R7 stray ack ignored
        do_ack(8'h02);
        check("R7 stray ack open", {31'd0, row_open[1]}, 32'd0);
        check("R7 stray ack pre", {24'd0, pre_req}, 32'd0);
        do_req(1, 16'h0001, K_MISS, "R7 miss after stray ack");

        // R6 never closes
        idle(150);
        check("R6 no pre", {24'd0, pre_req}, 32'd0);

        // R8 refresh
        check("R8 open before", {24'd0, row_open}, 32'h03);
        do_refresh();
        check("R8 pre all open", {24'd0, pre_req}, 32'h03);
        do_ack(8'h03);
        check("R8 closed", {24'd0, row_open}, 32'd0);

        // R5 each limit code
        for (int i = 0; i < 7; i++) begin
            limit_sel = codes[i];
            do_req(2, 16'(16'h0100 + i), K_MISS, "R5 miss");
            idle(lims[i]);
            check("R5 before limit", {31'd0, pre_req[2]}, 32'd0);
            idle(1);
            check("R5 at limit", {31'd0, pre_req[2]}, 32'd1);
            do_ack(8'h04);
            check("R7 closed after ack", {31'd0, row_open[2]}, 32'd0);
        end

        // R4 own request resets, other bank does not
        limit_sel = 3'b001;
        do_req(3, 16'h0AAA, K_MISS, "R4 miss");
        idle(5);
        do_req(3, 16'h0AAA, K_HIT, "R4 hit");
        do_req(5, 16'h0BBB, K_MISS, "R4 other bank");
        idle(15);
        check("R4 before", {31'd0, pre_req[3]}, 32'd0);
        idle(1);
        check("R4 at limit", {31'd0, pre_req[3]}, 32'd1);
        do_refresh();
        do_ack(8'hFF);
        check("R8 all closed", {24'd0, row_open}, 32'd0);

        // R9 request during pending precharge
        limit_sel = 3'b000;
        do_req(6, 16'h00A0, K_MISS, "R9 miss");
        idle(1);
        check("R5 zero limit", {31'd0, pre_req[6]}, 32'd1);
        do_req(6, 16'h00B0, K_CONF, "R9 conflict while pending");
        do_ack(8'h40);
        check("R9 reopened", {31'd0, row_open[6]}, 32'd1);
        do_req(6, 16'h00B0, K_HIT, "R9 hit on new row");
        idle(1);
        check("R9 zero limit again", {31'd0, pre_req[6]}, 32'd1);
        do_ack(8'h40);
        check("R9 closed", {31'd0, row_open[6]}, 32'd0);

        // R10 lowering the limit
        limit_sel = 3'b100;
        do_req(7, 16'hC0DE, K_MISS, "R10 miss");
        idle(40);
        check("R10 before change", {31'd0, pre_req[7]}, 32'd0);
        limit_sel = 3'b000;
        idle(1);
        check("R10 after change", {31'd0, pre_req[7]}, 32'd1);
        do_ack(8'h80);
        check("R10 closed", {31'd0, row_open[7]}, 32'd0);

        idle(2);
        check("R2 scoreboard drained", exp_q.size(), 32'd0);
        finish_run();
    end
endmodule